// File: doc/BRIEF.md
# Supply Supervisor Fault Latch and Shutdown Sequencer

This block decides when a secondary-side supply supervisor raises its fault output and its crowbar drive. It takes per-rail overvoltage and undervoltage flags from the analog comparators, a flag that says the input line is healthy, a remote-off request, a bias-valid flag and a two-bit fault mode. Every detection path must stay high for a number of consecutive clocks before it is believed. A qualified overvoltage is treated as dangerous. It sets two sticky latches, one for the fault output and one for the crowbar drive.

Undervoltage never drives the crowbar. Depending on the mode, it reaches the fault latch at once, after a start-up blanking interval, or not at all. The blanking interval is measured by an up-counter. That counter restarts whenever the input line drops, bias is lost, the fault output is high or the remote-off request falls. A remote-off request that goes high raises the fault output only after a programmable number of clocks. A falling request clears both latches and restarts the blanking.

Top module: `supv_fault_seq`

## Requirements
- R1: After reset both `fault_o` and `crowbar_o` are 0, and the crowbar latch comes out of reset cleared.
- R2: An overvoltage or undervoltage condition counts only after it has been present for QUAL_CYCLES consecutive clocks (default 5). A shorter pulse sets nothing.
- R3: A qualified overvoltage on any rail sets both `fault_o` and `crowbar_o`. Both stay high after the overvoltage goes away.
- R4: A 1-to-0 transition of `off_req` clears the fault latch, the crowbar latch and the blanking counter.
- R5: Undervoltage never sets `crowbar_o`. In mode 2'b01 a qualified undervoltage sets `fault_o` at once.
- R6: In mode 2'b10 a qualified undervoltage sets `fault_o` only once the blanking counter has reached `blank_limit` clocks.
- R7: The blanking counter is held at zero while `line_ok` is low, while `bias_ok` is low or while `fault_o` is high.
- R8: In modes 2'b00 and 2'b11 undervoltage has no effect on `fault_o`.
- R9: While `off_req` is high, `fault_o` goes high once the request has been held for `off_limit` clocks. The delay counter is held at zero while `off_req` is low.
- R10: While `bias_ok` is low the rail flags are ignored and no latch can be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bias_ok | input | 1 | Reference and bias are valid; detection is inhibited when low |
| ov_flags | input | NUM_RAILS | Per-rail overvoltage comparator flags |
| uv_flags | input | NUM_RAILS | Per-rail undervoltage comparator flags |
| line_ok | input | 1 | Input line voltage is sufficient (low = line loss) |
| off_req | input | 1 | Remote-off request (high = shut down) |
| fault_mode | input | 2 | 00 overvoltage only, 01 plus undervoltage, 10 plus blanked undervoltage, 11 undervoltage disabled |
| blank_limit | input | CNT_W | Start-up blanking length in clocks |
| off_limit | input | CNT_W | Remote-off shutdown delay in clocks |
| fault_o | output | 1 | Fault output |
| crowbar_o | output | 1 | Crowbar drive, overvoltage only |

## Verification
The bench sends overvoltage pulses one clock shorter than the qualification window. A filter that is off by one would latch a fault on such a glitch. It drops `line_ok` part-way through a blanking interval and then applies undervoltage. A counter that was not restarted would raise the fault too early. It checks every mode with the same undervoltage stimulus. An inverted or misdecoded mode would raise the crowbar, or raise the fault when it must stay low. It also holds `off_req` high across its full delay and then drops it, and drives overvoltage while bias is invalid. A delay that is short by one, a latch that fails to clear or a missing bias inhibit each shows up as a mismatch against the bench's cycle model.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    FM_OV_ONLY     = 2'b00,
    FM_OV_UV       = 2'b01,
    FM_OV_UV_BLANK = 2'b10,
    FM_UV_DISABLED = 2'b11
  } fault_mode_e;
endpackage

// File: rtl/supv_qual.sv
module supv_qual #(
  parameter int QUAL_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic qual_o
);
  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYCLES);

  logic [QW-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    if (!raw_i)
      run_d = '0;
    else if (run_q != QMAX)
      run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign qual_o = (run_q == QMAX);
endmodule

// File: rtl/supv_timer.sv
module supv_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)
      cnt_d = '0;
    else if (cnt_q < limit_i)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q >= limit_i);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/supv_latch.sv
module supv_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (clr_i)      q_d = 1'b0;
    else if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/supv_fault_seq.sv
module supv_fault_seq
  import supv_pkg::*;
#(
  parameter int NUM_RAILS   = 5,
  parameter int CNT_W       = 16,
  parameter int QUAL_CYCLES = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bias_ok,
  input  logic [NUM_RAILS-1:0] ov_flags,
  input  logic [NUM_RAILS-1:0] uv_flags,
  input  logic                 line_ok,
  input  logic                 off_req,
  input  logic [1:0]           fault_mode,
  input  logic [CNT_W-1:0]     blank_limit,
  input  logic [CNT_W-1:0]     off_limit,
  output logic                 fault_o,
  output logic                 crowbar_o
);
  localparam int NPATH = 2;
  localparam int P_OV  = 0;
  localparam int P_UV  = 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  // detection paths gated by bias, then qualified
  logic [NPATH-1:0] raw_path, qual_path;
  assign raw_path[P_OV] = bias_ok & (|ov_flags);
  assign raw_path[P_UV] = bias_ok & (|uv_flags);

  for (genvar g = 0; g < NPATH; g++) begin : g_qual
    supv_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .raw_i  (raw_path[g]),
      .qual_o (qual_path[g])
    );
  end

  logic ov_q, uv_q;
  assign ov_q = qual_path[P_OV];
  assign uv_q = qual_path[P_UV];

  // remote-off edge detect (reset high so a held-low request is benign)
  logic off_d_q, off_d_d, off_fall;
  assign off_d_d  = off_req;
  assign off_fall = off_d_q & ~off_req;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_d_q <= 1'b1;
    else        off_d_q <= off_d_d;
  end

  // blanking and shutdown-delay counters
  logic             blank_done, blank_clr, off_done;
  logic [CNT_W-1:0] blank_cnt, off_cnt;

  assign blank_clr = ~line_ok | ~bias_ok | fault_o | off_fall;

  supv_timer #(.CNT_W(CNT_W)) u_blank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_i   (blank_clr),
    .limit_i (blank_limit),
    .done_o  (blank_done),
    .cnt_o   (blank_cnt)
  );

  supv_timer #(.CNT_W(CNT_W)) u_offdly (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_i   (~off_req),
    .limit_i (off_limit),
    .done_o  (off_done),
    .cnt_o   (off_cnt)
  );

  // mode decode
  fault_mode_e mode;
  logic        uv_enable;
  assign mode = fault_mode_e'(fault_mode);
  always_comb begin
    case (mode)
      FM_OV_UV:       uv_enable = 1'b1;
      FM_OV_UV_BLANK: uv_enable = blank_done;
      default:        uv_enable = 1'b0;
    endcase
  end

  // latches
  logic fault_lat, crow_lat;

  supv_latch u_fault_lat (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (ov_q | (uv_q & uv_enable)),
    .clr_i (off_fall),
    .q_o   (fault_lat)
  );

  supv_latch u_crow_lat (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (ov_q),
    .clr_i (off_fall),
    .q_o   (crow_lat)
  );

  assign fault_o   = fault_lat | (off_req & off_done);
  assign crowbar_o = crow_lat;
endmodule

// File: rtl/supv_fault_seq_chk.sv
module supv_fault_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             bias_ok,
  input logic             line_ok,
  input logic             off_req,
  input logic             ov_q,
  input logic             fault_lat,
  input logic             fault_o,
  input logic             crowbar_o,
  input logic [CNT_W-1:0] blank_cnt,
  input logic [CNT_W-1:0] off_cnt
);
  // R3
  crow_implies_fault_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    crowbar_o |-> fault_o);

  // R5
  crow_only_ov_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(crowbar_o) |-> $past(ov_q));

  // R4
  off_fall_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(off_req) |=> (!crowbar_o && !fault_lat));

  // R7
  line_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !line_ok |=> (blank_cnt == '0));

  // R9
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !off_req |=> (off_cnt == '0));

  // R10
  bias_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(crowbar_o) |-> $past(bias_ok, 2));
endmodule

bind supv_fault_seq supv_fault_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bias_ok    (bias_ok),
  .line_ok    (line_ok),
  .off_req    (off_req),
  .ov_q       (ov_q),
  .fault_lat  (fault_lat),
  .fault_o    (fault_o),
  .crowbar_o  (crowbar_o),
  .blank_cnt  (blank_cnt),
  .off_cnt    (off_cnt)
);

// File: tb/supv_fault_seq_bench.sv
`timescale 1ns/1ps
module supv_fault_seq_bench;
  localparam int NR = 5;
  localparam int CW = 16;
  localparam int QC = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bias_ok, line_ok, off_req;
  logic [NR-1:0] ov_flags, uv_flags;
  logic [1:0]    fault_mode;
  logic [CW-1:0] blank_limit, off_limit;
  logic          fault_o, crowbar_o;

  always #2 clk = ~clk;

  supv_fault_seq #(.NUM_RAILS(NR), .CNT_W(CW), .QUAL_CYCLES(QC)) u_supv_fault_seq (
    .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .ov_flags(ov_flags),
    .uv_flags(uv_flags), .line_ok(line_ok), .off_req(off_req),
    .fault_mode(fault_mode), .blank_limit(blank_limit), .off_limit(off_limit),
    .fault_o(fault_o), .crowbar_o(crowbar_o)
  );

  // behavioural reference model
  int m_sync, m_ovrun, m_uvrun, m_bcnt, m_dcnt;
  bit m_fault, m_crow, m_offprev;
  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R1";
  bit finished = 0;

  function automatic bit exp_fault();
    return m_fault || (off_req && (m_dcnt >= int'(off_limit)));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_ovrun = 0; m_uvrun = 0; m_bcnt = 0; m_dcnt = 0;
      m_fault = 0; m_crow = 0; m_offprev = 1;
    end else begin
      bit ovr, uvr, ovok, uvok, fall, uven, fo, bdone;
      fo    = exp_fault();
      fall  = m_offprev && !off_req;
      m_offprev = off_req;
      if (m_sync < 2) begin
        m_sync++;
      end else begin
        ovr   = bias_ok && (ov_flags != 0);
        uvr   = bias_ok && (uv_flags != 0);
        ovok  = (m_ovrun == QC);
        uvok  = (m_uvrun == QC);
        bdone = (m_bcnt >= int'(blank_limit));
        uven  = (fault_mode == 2'b01) || (fault_mode == 2'b10 && bdone);
        if (fall) begin m_fault = 0; m_crow = 0; end
        else begin
          if (ovok || (uvok && uven)) m_fault = 1;
          if (ovok) m_crow = 1;
        end
        m_ovrun = ovr ? ((m_ovrun < QC) ? m_ovrun + 1 : QC) : 0;
        m_uvrun = uvr ? ((m_uvrun < QC) ? m_uvrun + 1 : QC) : 0;
        if (!line_ok || !bias_ok || fo || fall) m_bcnt = 0;
        else if (m_bcnt < int'(blank_limit)) m_bcnt++;
        if (!off_req) m_dcnt = 0;
        else if (m_dcnt < int'(off_limit)) m_dcnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      cycles++;
      compared++;
      if (fault_o !== exp_fault()) begin
        mismatched++;
        $display("FAIL %s fault_o actual=%0b expected=%0b at cycle %0d",
                 cur_req, fault_o, exp_fault(), cycles);
      end
      compared++;
      if (crowbar_o !== m_crow) begin
        mismatched++;
        $display("FAIL %s crowbar_o actual=%0b expected=%0b at cycle %0d",
                 cur_req, crowbar_o, m_crow, cycles);
      end
      if (cycles > 200000) begin
        mismatched++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        finished = 1;
        $finish;
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic off_pulse();
    off_req = 1'b1; tick(1);
    off_req = 1'b0; tick(4);
  endtask

  initial begin
    rst_n = 1'b0; bias_ok = 1'b1; line_ok = 1'b1; off_req = 1'b0;
    ov_flags = '0; uv_flags = '0; fault_mode = 2'b01;
    blank_limit = 16'd20; off_limit = 16'd30;
    // R1: reset state
    cur_req = "R1"; tick(4);
    rst_n = 1'b1; tick(4);
    // R2: overvoltage glitch one clock short of qualification
    cur_req = "R2"; fault_mode = 2'b00;
    ov_flags = 5'b00010; tick(QC - 1);
    ov_flags = '0; tick(8);
    // R3: sustained overvoltage latches fault and crowbar
    cur_req = "R3"; ov_flags = 5'b00100; tick(8);
    ov_flags = '0; tick(10);
    // R4: falling remote-off clears both latches
    cur_req = "R4"; off_pulse();
    // R5: undervoltage in immediate mode sets fault only
    cur_req = "R5"; fault_mode = 2'b01;
    uv_flags = 5'b00001; tick(8);
    uv_flags = '0; tick(5);
    off_pulse();
    // R8: undervoltage ignored in both disabled modes
    cur_req = "R8"; fault_mode = 2'b00;
    uv_flags = 5'b01000; tick(12);
    fault_mode = 2'b11; tick(12);
    uv_flags = '0; tick(2);
    // R6: blanked mode, undervoltage waits for blank_limit
    cur_req = "R6"; fault_mode = 2'b10;
    line_ok = 1'b0; tick(1); line_ok = 1'b1;
    uv_flags = 5'b10000; tick(40);
    uv_flags = '0; off_pulse();
    // R7: line loss mid-interval restarts blanking
    cur_req = "R7";
    line_ok = 1'b0; tick(2); line_ok = 1'b1; tick(15);
    line_ok = 1'b0; tick(1); line_ok = 1'b1;
    uv_flags = 5'b00010; tick(15);
    tick(15);
    uv_flags = '0; off_pulse();
    // R9: remote-off delay then clear
    cur_req = "R9"; fault_mode = 2'b00;
    off_req = 1'b1; tick(40);
    off_req = 1'b0; tick(5);
    // R10: bias invalid inhibits detection
    cur_req = "R10"; fault_mode = 2'b01;
    bias_ok = 1'b0; ov_flags = 5'b00001; uv_flags = 5'b00001; tick(20);
    bias_ok = 1'b1; tick(10);
    ov_flags = '0; uv_flags = '0; off_pulse();
    tick(3);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule